// File: doc/BRIEF.md
# Half-Duplex UART Transmitter with Automatic Direction Control

This block is the transmit side of a UART serving a shared two-wire half-duplex link. It takes bytes from a transmit queue through a valid/ready handshake, where the ready is a one-cycle pop strobe. It frames each byte and shifts it out on a serial line, using an oversampling tick from an external bit-rate generator. It also drives the direction input of an external line transceiver. When automatic direction mode is on, the direction line sits low while nothing is pending, so the transceiver listens. It rises a programmable number of bit periods before the first start bit and falls a programmable number of bit periods after the last stop bit.

A disable input stops transmission gracefully. A character already on the wire always finishes. No new character is started while the disable is high, and queued bytes stay in the queue until the disable is released. A one-cycle interrupt pulse reports that both the queue and the shifter have run dry. Independent three-state enables let the serial line and the direction line be released separately.

Top module: `uart_dir_tx`

## Requirements
- R1: With automatic direction mode on and no byte pending, `rtsOut` is low and `txOut` is high, including straight after reset.
- R2: With automatic direction mode on, `rtsOut` rises exactly `setupDelay`×16 bit ticks before the first start bit appears on `txOut`; a value of 0 makes both change in the same cycle.
- R3: Each character is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit, and every bit lasts 16 bit ticks.
- R4: When another byte is valid at the end of a stop bit, its start bit follows in the very next cycle, and `rtsOut` stays high between the two characters.
- R5: With automatic direction mode on, `rtsOut` falls exactly `holdDelay`×16 bit ticks after the final stop bit ends; a value of 0 drops it in the cycle right after.
- R6: `txEmptyIrq` is a one-cycle pulse in the cycle after a stop bit ends, and only if no byte is valid at that point; it does not fire when bytes remain queued.
- R7: Raising `txDisable` during a character lets that character complete in full; no further start bit is sent while `txDisable` stays high.
- R8: While `txDisable` is high, `fifoPop` stays low, so queued bytes are neither popped nor lost, and they are sent once `txDisable` is released.
- R9: `txOut` rests at logic high whenever no character is being shifted, including after a disabled stop.
- R10: `txOe` is the inverse of `txHiZ` and `rtsOe` is the inverse of `rtsHiZ`, and the two act independently of each other.
- R11: With automatic direction mode off, `rtsOut` stays low and characters start without any setup delay.
- R12: `fifoPop` is high for exactly one cycle per character, and only while `fifoValid` is high; the byte on `fifoData` in that cycle is the one sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Oversampling tick, 16 per bit period |
| fifoData | input | 8 | Byte at the head of the transmit queue |
| fifoValid | input | 1 | Transmit queue holds at least one byte |
| fifoPop | output | 1 | Pop strobe: head byte taken this cycle |
| autoDirEn | input | 1 | Enable automatic direction control |
| txDisable | input | 1 | Stop at the next character boundary |
| txHiZ | input | 1 | Release the serial output |
| rtsHiZ | input | 1 | Release the direction output |
| setupDelay | input | 8 | Bit periods from direction rise to start bit |
| holdDelay | input | 8 | Bit periods from last stop bit to direction fall |
| txOut | output | 1 | Serial data line |
| txOe | output | 1 | Output enable of the serial line |
| rtsOut | output | 1 | Transceiver direction line, high = transmit |
| rtsOe | output | 1 | Output enable of the direction line |
| txEmptyIrq | output | 1 | Pulse: queue and shifter both empty |

## Verification
The assertions assume that the automatic direction mode does not change while a burst is in flight. They also assume that the queue model only drops `fifoValid` after a pop, and never withdraws a byte in any other way. The stimulus respects both assumptions. It changes the mode, the delays and the three-state controls only while the transmitter is idle, and its queue model removes a byte only after the cycle in which the pop was seen. The disable input is the one control raised mid-character, because graceful stopping is exactly the behaviour under test.

// File: rtl/uart_dir_pkg.sv
package uart_dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SEND,
    ST_HOLD
  } dirState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture head byte and start a frame
    logic squelch;  // force the line to mark while idle
  } dpCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic busy;       // a frame is on the wire
    logic frameDone;  // last tick of the stop bit this cycle
  } dpStat_t;

endpackage

// File: rtl/uart_dir_datapath.sv
module uart_dir_datapath
  import uart_dir_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] loadData,
  output dpStat_t           stat,
  output logic              txLine
);

  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned TICK_W     = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shifter;
  logic [TICK_W-1:0]     tickCnt;
  logic [IDX_W-1:0]      bitIdx;
  logic                  busy;
  logic                  bitEnd;
  logic                  lastBit;

  assign bitEnd  = busy && bitTick && (tickCnt == LAST_TICK);
  assign lastBit = (bitIdx == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '1;
      tickCnt <= '0;
      bitIdx  <= '0;
      busy    <= 1'b0;
    end else if (cmd.load) begin
      // stop bit high, data, start bit low in the LSB position
      shifter <= {1'b1, loadData, 1'b0};
      tickCnt <= '0;
      bitIdx  <= '0;
      busy    <= 1'b1;
    end else if (busy && bitTick) begin
      if (tickCnt == LAST_TICK) begin
        tickCnt <= '0;
        if (lastBit) begin
          busy    <= 1'b0;
          shifter <= '1;
        end else begin
          shifter <= {1'b1, shifter[FRAME_BITS-1:1]};
          bitIdx  <= bitIdx + 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign stat.busy      = busy;
  assign stat.frameDone = bitEnd && lastBit;
  assign txLine         = (busy && !cmd.squelch) ? shifter[0] : 1'b1;

endmodule

// File: rtl/uart_dir_ctrl.sv
module uart_dir_ctrl
  import uart_dir_pkg::*;
#(
  parameter int unsigned DELAY_W       = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               fifoValid,
  input  logic               txDisable,
  input  logic               autoDirEn,
  input  logic [DELAY_W-1:0] setupDelay,
  input  logic [DELAY_W-1:0] holdDelay,
  input  dpStat_t            stat,
  output dpCmd_t             cmd,
  output logic               fifoPop,
  output logic               rtsLine,
  output logic               emptyIrq
);

  localparam int unsigned TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned CNT_W  = DELAY_W + TICK_W + 1;
  localparam logic [CNT_W-1:0] TPB = CNT_W'(TICKS_PER_BIT);

  dirState_t        state, stateNext;
  logic [CNT_W-1:0] remCnt, remNext;
  logic             irqQ;
  logic             canStart;
  logic             loadNow;
  logic             countEnd;
  logic [CNT_W-1:0] setupTicks;
  logic [CNT_W-1:0] holdTicks;

  assign canStart   = fifoValid && !txDisable;
  assign setupTicks = CNT_W'(setupDelay) * TPB;
  assign holdTicks  = CNT_W'(holdDelay) * TPB;
  assign countEnd   = bitTick && (remCnt == CNT_W'(1));

  always_comb begin
    stateNext = state;
    remNext   = remCnt;
    loadNow   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (canStart) begin
          if (autoDirEn && (setupDelay != '0)) begin
            stateNext = ST_SETUP;
            remNext   = setupTicks;
          end else begin
            loadNow   = 1'b1;
            stateNext = ST_SEND;
          end
        end
      end
      ST_SETUP: begin
        if (countEnd) begin
          if (canStart) begin
            loadNow   = 1'b1;
            stateNext = ST_SEND;
          end else begin
            stateNext = ST_IDLE;
          end
        end else if (bitTick) begin
          remNext = remCnt - 1'b1;
        end
      end
      ST_SEND: begin
        if (stat.frameDone) begin
          if (canStart) begin
            loadNow = 1'b1;
          end else if (autoDirEn && (holdDelay != '0)) begin
            stateNext = ST_HOLD;
            remNext   = holdTicks;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (countEnd) begin
          stateNext = ST_IDLE;
        end else if (bitTick) begin
          remNext = remCnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
      irqQ   <= 1'b0;
    end else begin
      state  <= stateNext;
      remCnt <= remNext;
      irqQ   <= stat.frameDone && !fifoValid;
    end
  end

  assign cmd.load    = loadNow;
  assign cmd.squelch = (state == ST_IDLE) || (state == ST_SETUP);
  assign fifoPop     = loadNow;
  assign rtsLine     = autoDirEn && (state != ST_IDLE);
  assign emptyIrq    = irqQ;

endmodule

// File: rtl/uart_dir_tx.sv
module uart_dir_tx
  import uart_dir_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned DELAY_W       = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic [DATA_W-1:0]  fifoData,
  input  logic               fifoValid,
  output logic               fifoPop,
  input  logic               autoDirEn,
  input  logic               txDisable,
  input  logic               txHiZ,
  input  logic               rtsHiZ,
  input  logic [DELAY_W-1:0] setupDelay,
  input  logic [DELAY_W-1:0] holdDelay,
  output logic               txOut,
  output logic               txOe,
  output logic               rtsOut,
  output logic               rtsOe,
  output logic               txEmptyIrq
);

  dpCmd_t  cmd;
  dpStat_t stat;

  uart_dir_ctrl #(
    .DELAY_W      (DELAY_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .fifoValid (fifoValid),
    .txDisable (txDisable),
    .autoDirEn (autoDirEn),
    .setupDelay(setupDelay),
    .holdDelay (holdDelay),
    .stat      (stat),
    .cmd       (cmd),
    .fifoPop   (fifoPop),
    .rtsLine   (rtsOut),
    .emptyIrq  (txEmptyIrq)
  );

  uart_dir_datapath #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .cmd     (cmd),
    .loadData(fifoData),
    .stat    (stat),
    .txLine  (txOut)
  );

  assign txOe  = !txHiZ;
  assign rtsOe = !rtsHiZ;

endmodule

// File: rtl/uart_dir_tx_chk.sv
module uart_dir_tx_chk (
  input logic clk,
  input logic rstN,
  input logic fifoValid,
  input logic fifoPop,
  input logic txDisable,
  input logic autoDirEn,
  input logic txOut,
  input logic rtsOut,
  input logic txEmptyIrq
);

  assert_pop_needs_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoValid);

  assert_pop_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  assert_no_pop_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !txDisable);

  assert_manual_rts_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !autoDirEn |-> !rtsOut);

  assert_dir_before_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (autoDirEn && !txOut) |-> rtsOut);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |=> !txEmptyIrq);

  assert_irq_queue_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |-> !$past(fifoValid));

endmodule

bind uart_dir_tx uart_dir_tx_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoValid (fifoValid),
  .fifoPop   (fifoPop),
  .txDisable (txDisable),
  .autoDirEn (autoDirEn),
  .txOut     (txOut),
  .rtsOut    (rtsOut),
  .txEmptyIrq(txEmptyIrq)
);

// File: tb/test_uart_dir_tx.sv
module test_uart_dir_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [7:0] fifoData = 8'h00;
  logic       fifoValid = 1'b0;
  logic       fifoPop;
  logic       autoDirEn = 1'b1;
  logic       txDisable = 1'b0;
  logic       txHiZ = 1'b0;
  logic       rtsHiZ = 1'b0;
  logic [7:0] setupDelay = 8'd0;
  logic [7:0] holdDelay = 8'd0;
  logic       txOut, txOe, rtsOut, rtsOe, txEmptyIrq;

  int checks = 0;
  int errors = 0;

  logic [7:0] fifoQ[$];
  logic [7:0] expQ[$];
  logic       popSeen = 1'b0;

  // monitor state
  bit         inFrame = 0;
  int         tickNum = 0;
  logic [7:0] rxByte = 8'h00;
  int         setupTicks = 0;
  int         holdTicks = 0;
  bit         firstOfBurst = 1;
  int         sinceEnd = 1000;
  logic       prevRts = 1'b0;
  int         rtsFalls = 0;
  int         framesRx = 0;
  int         irqCount = 0;
  int         rtsHighInFrame = 0;
  int         expSetup = 0;
  int         expHold = 0;

  uart_dir_tx i_uart_dir_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .fifoData(fifoData), .fifoValid(fifoValid), .fifoPop(fifoPop),
    .autoDirEn(autoDirEn), .txDisable(txDisable),
    .txHiZ(txHiZ), .rtsHiZ(rtsHiZ),
    .setupDelay(setupDelay), .holdDelay(holdDelay),
    .txOut(txOut), .txOe(txOe), .rtsOut(rtsOut), .rtsOe(rtsOe),
    .txEmptyIrq(txEmptyIrq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tick every second cycle, driven just after the edge
  initial begin
    forever begin
      @(posedge clk); #1 bitTick = 1'b1;
      @(posedge clk); #1 bitTick = 1'b0;
    end
  end

  // queue model: pop recorded at the edge, applied at the following negedge
  always @(posedge clk) popSeen <= fifoPop && fifoValid;

  always @(negedge clk) begin
    if (popSeen && fifoQ.size() > 0) void'(fifoQ.pop_front());
    fifoValid = (fifoQ.size() > 0);
    fifoData  = (fifoQ.size() > 0) ? fifoQ[0] : 8'h00;
  end

  task automatic pushByte(input logic [7:0] b);
    fifoQ.push_back(b);
    expQ.push_back(b);
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    if (!rstN) begin
      inFrame = 0; firstOfBurst = 1; prevRts = 1'b0;
      setupTicks = 0; holdTicks = 0;
    end else begin
      if (txEmptyIrq) begin
        irqCount++;
        chk(sinceEnd == 0 && fifoQ.size() == 0, "R6 irq timing", sinceEnd, 0);
      end
      if (inFrame) begin
        if (rtsOut) rtsHighInFrame++;
        if (bitTick) begin
          tickNum++;
          if (tickNum % 16 == 8) begin
            if (tickNum / 16 == 0) chk(txOut == 1'b0, "R3 start bit", txOut, 0);
            else if (tickNum / 16 <= 8) rxByte[tickNum/16-1] = txOut;
            else chk(txOut == 1'b1, "R3 stop bit", txOut, 1);
          end
          if (tickNum == 160) begin
            inFrame = 0; sinceEnd = 0; holdTicks = 0; framesRx++;
            if (expQ.size() == 0) chk(0, "R3 unexpected frame", rxByte, -1);
            else begin
              logic [7:0] e;
              e = expQ.pop_front();
              chk(rxByte == e, "R3 data byte", rxByte, e);
            end
          end
        end
      end else if (!txOut) begin
        inFrame = 1;
        tickNum = bitTick ? 1 : 0;
        if (firstOfBurst) begin
          chk(setupTicks == (autoDirEn ? expSetup * 16 : 0), "R2 setup ticks",
              setupTicks, autoDirEn ? expSetup * 16 : 0);
          firstOfBurst = 0;
        end else begin
          chk(sinceEnd == 0, "R4 back-to-back gap", sinceEnd, 0);
        end
      end else begin
        sinceEnd++;
        if (rtsOut && bitTick) begin setupTicks++; holdTicks++; end
      end
      if (prevRts && !rtsOut) begin
        rtsFalls++;
        chk(holdTicks == expHold * 16, "R5 hold ticks", holdTicks, expHold * 16);
      end
      if (!rtsOut) begin setupTicks = 0; firstOfBurst = 1; end
      prevRts = rtsOut;
    end
  end

  task automatic waitIdle();
    int stable = 0;
    while (stable < 8) begin
      @(negedge clk);
      if (fifoQ.size() == 0 && !inFrame && !rtsOut && !fifoValid) stable++;
      else stable = 0;
    end
  endtask

  task automatic setCfg(input bit a, input int s, input int h);
    @(posedge clk); #1;
    autoDirEn = a; setupDelay = 8'(s); holdDelay = 8'(h);
    expSetup = s; expHold = h;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int f0, i0, r0;
    repeat (5) @(negedge clk);
    // R1, R9, R12 reset state
    chk(txOut == 1'b1, "R9 reset tx", txOut, 1);
    chk(rtsOut == 1'b0, "R1 reset rts", rtsOut, 0);
    chk(fifoPop == 1'b0, "R12 reset pop", fifoPop, 0);
    chk(txEmptyIrq == 1'b0, "R6 reset irq", txEmptyIrq, 0);
    @(posedge clk); #1 rstN = 1'b1;

    // single byte with setup and hold
    setCfg(1, 2, 1);
    f0 = framesRx; i0 = irqCount; r0 = rtsFalls;
    pushByte(8'hA5);
    waitIdle();
    chk(framesRx - f0 == 1, "R3 frame count", framesRx - f0, 1);
    chk(irqCount - i0 == 1, "R6 irq count", irqCount - i0, 1);
    chk(rtsFalls - r0 == 1, "R5 rts fall count", rtsFalls - r0, 1);
    chk(rtsOut == 1'b0 && txOut == 1'b1, "R1 idle lines", {rtsOut, txOut}, 1);

    // back-to-back burst with zero delays
    setCfg(1, 0, 0);
    f0 = framesRx; i0 = irqCount; r0 = rtsFalls;
    pushByte(8'h00); pushByte(8'hFF); pushByte(8'h3C);
    waitIdle();
    chk(framesRx - f0 == 3, "R4 burst frames", framesRx - f0, 3);
    chk(rtsFalls - r0 == 1, "R4 single rts drop", rtsFalls - r0, 1);
    chk(irqCount - i0 == 1, "R6 one irq per burst", irqCount - i0, 1);

    // longer delays
    setCfg(1, 3, 2);
    f0 = framesRx;
    pushByte(8'h81);
    waitIdle();
    chk(framesRx - f0 == 1, "R2 delayed frame", framesRx - f0, 1);

    // graceful disable mid-character
    setCfg(1, 1, 1);
    f0 = framesRx; i0 = irqCount; r0 = rtsFalls;
    pushByte(8'h55); pushByte(8'h12); pushByte(8'h34);
    while (!inFrame) @(negedge clk);
    repeat (100) @(posedge clk);
    #1 txDisable = 1'b1;
    repeat (900) @(negedge clk);
    chk(framesRx - f0 == 1, "R7 only current char", framesRx - f0, 1);
    chk(fifoQ.size() == 2, "R8 queue kept", fifoQ.size(), 2);
    chk(irqCount - i0 == 0, "R6 no irq with data", irqCount - i0, 0);
    chk(txOut == 1'b1, "R9 tx rests high", txOut, 1);
    chk(rtsOut == 1'b0 && rtsFalls - r0 == 1, "R7 rts released", rtsOut, 0);
    chk(fifoPop == 1'b0, "R8 no pop disabled", fifoPop, 0);
    @(posedge clk); #1 txDisable = 1'b0;
    waitIdle();
    chk(framesRx - f0 == 3, "R8 queued sent", framesRx - f0, 3);
    chk(irqCount - i0 == 1, "R6 irq after drain", irqCount - i0, 1);

    // manual direction mode
    setCfg(0, 4, 4);
    f0 = framesRx; r0 = rtsFalls; rtsHighInFrame = 0;
    pushByte(8'h6E); pushByte(8'h91);
    waitIdle();
    chk(framesRx - f0 == 2, "R11 frames sent", framesRx - f0, 2);
    chk(rtsHighInFrame == 0, "R11 rts stays low", rtsHighInFrame, 0);
    chk(rtsFalls - r0 == 0, "R11 no rts edge", rtsFalls - r0, 0);

    // three-state controls
    @(posedge clk); #1 txHiZ = 1'b1; rtsHiZ = 1'b0;
    @(negedge clk);
    chk(txOe == 1'b0 && rtsOe == 1'b1, "R10 tx released", {txOe, rtsOe}, 1);
    @(posedge clk); #1 txHiZ = 1'b0; rtsHiZ = 1'b1;
    @(negedge clk);
    chk(txOe == 1'b1 && rtsOe == 1'b0, "R10 rts released", {txOe, rtsOe}, 2);
    @(posedge clk); #1 rtsHiZ = 1'b0;
    @(negedge clk);
    chk(txOe == 1'b1 && rtsOe == 1'b1, "R10 both driven", {txOe, rtsOe}, 3);

    chk(expQ.size() == 0, "R12 every byte sent once", expQ.size(), 0);
    finishRun();
  end

endmodule